// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Lanes

This block models a single-clock synchronous SRAM with a pipelined read path. Each word is 36 bits wide, arranged as four 9-bit byte lanes, and each lane holds eight data bits plus one parity bit. Every synchronous input is captured on the rising clock edge. An access starts when either of two active-low address strobes is asserted. After that, a 2-bit burst counter supplies the next three word addresses whenever the advance input is low. A static mode input chooses between a linear burst order and an interleaved one.

Writes are masked per lane. A global write forces all four lanes, and the individual lane enables count only while the shared lane-write enable is low. Writes pass through a one-entry buffer before they reach the array. A read in the very next cycle takes each written lane from that buffer, so it sees the new data at once. Read data appears two clock edges after the address is captured. The chip enable travels with the access, so a deselected cycle produces no output, and the asynchronous output enable gates the valid indication.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, `rvalid_o` is 0 and `rdata_o` is all zeros.
- R2: A read captured at clock edge n presents its word on `rdata_o` with `rvalid_o` high after edge n+2, and not before.
- R3: A cycle with either strobe low loads `addr_i` as the burst start only when `ce_ni` is low. With `ce_ni` high it deselects: that cycle and the following continuation cycles make no access and give no output.
- R4: A cycle with `strobe_p_ni` low is always a read, whatever the write inputs are, including when `strobe_c_ni` is low in the same cycle. A cycle started by `strobe_c_ni` alone honours the write inputs.
- R5: In a continuation cycle (both strobes high) with `adv_ni` high, the burst counter holds and the same address is accessed again.
- R6: With `interleave_i` low, each continuation cycle with `adv_ni` low adds 1 modulo 4 to the two low address bits. The upper address bits stay those of the start address.
- R7: With `interleave_i` high, the two low address bits are the start's low bits XOR the burst count (0,1,2,3, wrapping).
- R8: Lane i is bits [9i+8:9i] of the word, and bit 9i+8 is its parity bit. With `byte_we_ni` low and `all_we_ni` high, lane i is written exactly when `lane_we_ni[i]` is low. With `byte_we_ni` high, `lane_we_ni` has no effect.
- R9: With `all_we_ni` low, all four lanes are written, whatever `byte_we_ni` and `lane_we_ni` are.
- R10: A read of an address in the cycle right after a write to it returns the new value in the written lanes and the old value in the others.
- R11: With `oe_ni` high, `rvalid_o` is 0 and `rdata_o` is zero. Dropping `oe_ni` while a read result is present shows that result at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, captured on a strobe |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| ce_ni | input | 1 | Chip enable, active low |
| strobe_p_ni | input | 1 | Processor address strobe, active low, read-only start, priority |
| strobe_c_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| lane_we_ni | input | 4 | Per-lane write enables, active low |
| byte_we_ni | input | 1 | Enables the per-lane write enables, active low |
| all_we_ni | input | 1 | Global write of all lanes, active low |
| interleave_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
On every cycle the assertions check the address sequence of the burst: a hold when advance is high, and a linear step when it is low. They also check that deselects and processor-strobe cycles never write, and that the valid output keeps its two-edge spacing from the issued read under the output enable. The bench scenarios are the only check on stored contents. They cover the interleaved order, lane masking with its parity bits, the partial pass-through merge, and that ignored write inputs leave memory unchanged. To do this, the bench fills every address and then reads back every burst start offset against an arithmetic model.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;

  function automatic logic [CNT_W-1:0] burst_low(input logic [CNT_W-1:0] start,
                                                 input logic [CNT_W-1:0] cnt,
                                                 input logic             interleave);
    return interleave ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/burst_sram_burst.sv
module burst_sram_burst import burst_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] start_i,
  output logic              act_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              act_q;

  assign cnt_n  = adv_i ? cnt_q + CNT_W'(1) : cnt_q;
  assign addr_o = {base_q[ADDR_W-1:CNT_W], burst_low(base_q[CNT_W-1:0], cnt_n, interleave_i)};
  assign act_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= start_i;
      cnt_q  <= '0;
      act_q  <= sel_i;
    end else begin
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl import burst_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  logic              ce_ni,
  input  logic              strobe_p_ni,
  input  logic              strobe_c_ni,
  input  logic              adv_ni,
  input  lane_mask_t        lane_we_ni,
  input  logic              byte_we_ni,
  input  logic              all_we_ni,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic              acc_rd_o,
  output lane_mask_t        wr_mask_o,
  output word_t             wr_data_o
);
  logic [ADDR_W-1:0] addr_q;
  word_t             wdata_q;
  logic              ce_nq, sp_nq, sc_nq, adv_nq, bwe_nq, gwe_nq;
  lane_mask_t        lane_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      ce_nq   <= 1'b1;
      sp_nq   <= 1'b1;
      sc_nq   <= 1'b1;
      adv_nq  <= 1'b1;
      lane_nq <= '1;
      bwe_nq  <= 1'b1;
      gwe_nq  <= 1'b1;
    end else begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      ce_nq   <= ce_ni;
      sp_nq   <= strobe_p_ni;
      sc_nq   <= strobe_c_ni;
      adv_nq  <= adv_ni;
      lane_nq <= lane_we_ni;
      bwe_nq  <= byte_we_ni;
      gwe_nq  <= all_we_ni;
    end
  end

  logic              load, sel, act;
  logic [ADDR_W-1:0] burst_addr;
  lane_mask_t        lane_req;
  logic              acc_v, rd_only;

  assign load = ~sp_nq | ~sc_nq;
  assign sel  = ~ce_nq;

  burst_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .sel_i        (sel),
    .adv_i        (~adv_nq),
    .interleave_i (interleave_i),
    .start_i      (addr_q),
    .act_o        (act),
    .addr_o       (burst_addr)
  );

  always_comb begin
    if (!gwe_nq)      lane_req = '1;
    else if (!bwe_nq) lane_req = ~lane_nq;
    else              lane_req = '0;
  end

  // processor strobe wins and always starts a read
  assign acc_v      = load ? sel : act;
  assign rd_only    = load & ~sp_nq;
  assign acc_addr_o = load ? addr_q : burst_addr;
  assign wr_mask_o  = (acc_v && !rd_only) ? lane_req : '0;
  assign acc_rd_o   = acc_v && (wr_mask_o == '0);
  assign wr_data_o  = wdata_q;
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array import burst_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_rd_i,
  input  lane_mask_t        wr_mask_i,
  input  word_t             wr_data_i,
  output word_t             rd_data_o,
  output logic              rd_valid_o
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t             mem [DEPTH];
  logic              wb_v;
  logic [ADDR_W-1:0] wb_addr;
  lane_mask_t        wb_mask;
  word_t             wb_data;
  word_t             merged;
  word_t             rd_q;
  logic              rv_q;
  logic              wb_hit;

  // writes commit one cycle late; the buffer feeds the next read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_v    <= 1'b0;
      wb_addr <= '0;
      wb_mask <= '0;
      wb_data <= '0;
    end else begin
      wb_v    <= |wr_mask_i;
      wb_addr <= acc_addr_i;
      wb_mask <= wr_mask_i;
      wb_data <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (wb_v && wb_mask[l]) mem[wb_addr][l*LANE_W +: LANE_W] <= wb_data[l*LANE_W +: LANE_W];
    end
  end

  assign wb_hit = wb_v && (wb_addr == acc_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (wb_hit && wb_mask[g]) ? wb_data[g*LANE_W +: LANE_W]
                                                               : mem[acc_addr_i][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      rv_q <= 1'b0;
    end else begin
      rv_q <= acc_rd_i;
      if (acc_rd_i) rd_q <= merged;
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = rv_q;
endmodule

// File: rtl/burst_sram.sv
module burst_sram import burst_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              ce_ni,
  input  logic              strobe_p_ni,
  input  logic              strobe_c_ni,
  input  logic              adv_ni,
  input  logic [LANES-1:0]  lane_we_ni,
  input  logic              byte_we_ni,
  input  logic              all_we_ni,
  input  logic              interleave_i,
  input  logic              oe_ni,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_rd;
  lane_mask_t        wr_mask;
  word_t             wr_data;
  word_t             arr_data;
  logic              arr_valid;
  word_t             out_q;
  logic              out_v_q;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .ce_ni        (ce_ni),
    .strobe_p_ni  (strobe_p_ni),
    .strobe_c_ni  (strobe_c_ni),
    .adv_ni       (adv_ni),
    .lane_we_ni   (lane_we_ni),
    .byte_we_ni   (byte_we_ni),
    .all_we_ni    (all_we_ni),
    .interleave_i (interleave_i),
    .acc_addr_o   (acc_addr),
    .acc_rd_o     (acc_rd),
    .wr_mask_o    (wr_mask),
    .wr_data_o    (wr_data)
  );

  burst_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_addr_i (acc_addr),
    .acc_rd_i   (acc_rd),
    .wr_mask_i  (wr_mask),
    .wr_data_i  (wr_data),
    .rd_data_o  (arr_data),
    .rd_valid_o (arr_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      out_v_q <= 1'b0;
    end else begin
      out_q   <= arr_data;
      out_v_q <= arr_valid;
    end
  end

  assign rvalid_o = out_v_q & ~oe_ni;
  assign rdata_o  = rvalid_o ? out_q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk import burst_sram_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              strobe_p_ni,
  input logic              strobe_c_ni,
  input logic              adv_ni,
  input logic              interleave_i,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_rd,
  input lane_mask_t        wr_mask,
  input logic              rvalid_o
);
  // set from the second edge after reset, when $past of an input matches the capture stage
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!rvalid_o);
    end
  end

  assert_read_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(acc_rd, 2));

  assert_deselect_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(!(strobe_p_ni && strobe_c_ni) && ce_ni) |-> !acc_rd && (wr_mask == '0));

  assert_proc_read_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(!strobe_p_ni) |-> (wr_mask == '0));

  assert_hold_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(strobe_p_ni && strobe_c_ni && adv_ni) && (interleave_i == $past(interleave_i))
    |-> $stable(acc_addr));

  assert_linear_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(strobe_p_ni && strobe_c_ni && !adv_ni) && !interleave_i && $past(!interleave_i)
    |-> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1)
        && (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

  assert_oe_shows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni && $past(acc_rd, 2) |-> rvalid_o);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ce_ni        (ce_ni),
  .strobe_p_ni  (strobe_p_ni),
  .strobe_c_ni  (strobe_c_ni),
  .adv_ni       (adv_ni),
  .interleave_i (interleave_i),
  .oe_ni        (oe_ni),
  .acc_addr     (acc_addr),
  .acc_rd       (acc_rd),
  .wr_mask      (wr_mask),
  .rvalid_o     (rvalid_o)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wdata = '0;
  logic          ce_n = 1'b1, sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic          bwe_n = 1'b1, gwe_n = 1'b1, mode = 1'b0, oe_n = 1'b0;
  logic [35:0]   rdata;
  logic          rvalid;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW)) u_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .ce_ni(ce_n),
    .strobe_p_ni(sp_n), .strobe_c_ni(sc_n), .adv_ni(adv_n), .lane_we_ni(lane_n),
    .byte_we_ni(bwe_n), .all_we_ni(gwe_n), .interleave_i(mode), .oe_ni(oe_n),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // reference state
  logic [35:0]   ref_mem [NW];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_act = 1'b0;
  logic          pv [3];
  logic [35:0]   pd [3];
  string         pt [3];

  function automatic logic [35:0] pat(input int x);
    return 36'(x) * 36'h00F1E2D3C + 36'h5A5A5A5A5;
  endfunction

  task automatic check_out();
    logic        ev;
    logic [35:0] ed;
    ev = pv[2] && !oe_n;
    ed = ev ? pd[2] : 36'h0;
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", pt[2], rvalid, rdata, ev, ed);
    end
  endtask

  task automatic step(input logic s_p, input logic s_c, input logic ce, input logic adv,
                      input logic [3:0] ln, input logic bw, input logic gw,
                      input logic [AW-1:0] a, input logic [35:0] d, input string tag);
    logic          load, v, proc;
    logic [AW-1:0] ea;
    logic [3:0]    lw, m;
    @(negedge clk);
    check_out();
    pv[2] = pv[1]; pd[2] = pd[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
    sp_n = s_p; sc_n = s_c; ce_n = ce; adv_n = adv; lane_n = ln;
    bwe_n = bw; gwe_n = gw; addr = a; wdata = d;
    load = !s_p || !s_c;
    if (load) begin
      v = !ce; ea = a; proc = !s_p;
      m_act = !ce; m_base = a; m_cnt = 2'd0;
    end else begin
      if (!adv) m_cnt = m_cnt + 2'd1;
      v = m_act; proc = 1'b0;
      ea = {m_base[AW-1:2], mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
    end
    lw = !gw ? 4'hF : (!bw ? ~ln : 4'h0);
    m  = (v && !(load && proc)) ? lw : 4'h0;
    pv[0] = 1'b0; pd[0] = '0; pt[0] = tag;
    if (v && m == 4'h0) begin
      pv[0] = 1'b1; pd[0] = ref_mem[ea];
    end
    for (int l = 0; l < 4; l++)
      if (m[l]) ref_mem[ea][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 1, 1, 4'hF, 1, 1, '0, '0, "R3");
  endtask

  task automatic cont_rd(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; pt[i] = "R1"; end
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rvalid !== 1'b0 || rdata !== 36'h0) begin
      fails++;
      $display("FAIL R1: valid=%0b data=%h expected valid=0 data=0", rvalid, rdata);
    end
    rst_n = 1'b1;
    idle(3);

    // R9 + R6: fill every word by global-write linear bursts
    for (int b = 0; b < NW/4; b++) begin
      step(1, 0, 0, 1, 4'hF, 1, 0, AW'(b*4), pat(b*4), "R9");
      for (int k = 1; k < 4; k++) step(1, 1, 1, 0, 4'hF, 1, 0, '0, pat(b*4+k), "R6");
    end
    idle(2);

    // R2/R6/R4: linear read bursts from every start offset; upper half uses both strobes
    for (int b = 0; b < NW/4; b++) begin
      if (b < NW/8) step(0, 1, 0, 1, 4'hF, 1, 1, AW'(b*4 + b%4), '0, "R2");
      else          step(0, 0, 0, 1, 4'hF, 1, 1, AW'(b*4 + b%4), '0, "R4");
      cont_rd(3, "R6");
    end
    idle(3);

    // R7: interleaved order
    mode = 1'b1;
    idle(2);
    for (int b = 0; b < 8; b++) begin
      step(1, 0, 0, 1, 4'hF, 1, 1, AW'(b*8 + b%4), '0, "R7");
      cont_rd(5, "R7");
    end
    idle(3);
    mode = 1'b0;
    idle(2);

    // R5: holding the counter
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(22), '0, "R5");
    step(1, 1, 1, 1, 4'hF, 1, 1, '0, '0, "R5");
    step(1, 1, 1, 1, 4'hF, 1, 1, '0, '0, "R5");
    step(1, 1, 1, 0, 4'hF, 1, 1, '0, '0, "R5");
    step(1, 1, 1, 1, 4'hF, 1, 1, '0, '0, "R5");
    cont_rd(2, "R5");
    idle(3);

    // R8/R10: every lane mask, read back in the next cycle
    for (int mk = 1; mk < 16; mk++) begin
      step(1, 0, 0, 1, ~4'(mk), 0, 1, AW'(9), pat(100 + mk), "R8");
      step(1, 0, 0, 1, 4'hF, 1, 1, AW'(9), '0, "R10");
    end
    // partial write inside a burst, read next cycle
    step(1, 0, 0, 1, 4'b1010, 0, 1, AW'(40), pat(300), "R10");
    step(1, 1, 1, 0, 4'b0110, 0, 1, '0, pat(301), "R8");
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(41), '0, "R10");
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(40), '0, "R10");
    // lane enables ignored while byte_we_ni high
    step(1, 0, 0, 1, 4'h0, 1, 1, AW'(9), pat(400), "R8");
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(9), '0, "R8");
    // global write overrides lane enables
    step(1, 0, 0, 1, 4'hF, 1, 0, AW'(9), pat(401), "R9");
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(9), '0, "R9");
    idle(3);

    // R4: processor strobe ignores write inputs
    step(0, 1, 0, 1, 4'h0, 0, 0, AW'(12), pat(500), "R4");
    step(0, 0, 0, 1, 4'h0, 0, 0, AW'(12), pat(501), "R4");
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(12), '0, "R4");
    idle(3);

    // R3: deselect, then continuation writes must not land
    step(1, 0, 1, 1, 4'hF, 1, 1, AW'(13), '0, "R3");
    step(1, 1, 1, 0, 4'hF, 1, 0, '0, pat(600), "R3");
    step(1, 1, 1, 0, 4'hF, 1, 0, '0, pat(601), "R3");
    step(0, 1, 0, 1, 4'hF, 1, 1, AW'(13), '0, "R3");
    cont_rd(3, "R3");
    idle(3);

    // R11: output enable gating
    step(1, 0, 0, 1, 4'hF, 1, 1, AW'(32), '0, "R11");
    cont_rd(3, "R11");
    oe_n = 1'b1;
    cont_rd(3, "R11");
    oe_n = 1'b0;
    cont_rd(2, "R11");
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule